// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking tables kept in memory. A request carries the virtual address, a context number and a read/write flag. The walker first reads the context entry for that context, then follows table descriptors through up to three levels of page tables. A page entry can appear at level 1 (16 MB page), level 2 (256 KB page) or level 3 (4 KB page). The walk returns the physical address, a page-size code and the final page entry.

Memory is reached through a simple word port with a request/acknowledge pair, so each access may take any number of cycles. When a page entry is found, the walker sets its referenced bit, and on a write also its modified bit. It stores the entry back to memory only if one of those bits was clear. An entry of the wrong kind for its level ends the walk with a fault, a fault type and the level reached. When translation is switched off, the address passes straight through with full access and memory is not touched. Permission checks and TLB storage are handled by neighbouring blocks.

Top module: `mmu_table_walker`

## Requirements
- R1: A request is taken when `req_valid` is high while `busy` is low. `busy` is high from the next cycle up to and including the cycle of `resp_valid`. While `busy` is low, `mem_req` stays low.
- R2: If `mmu_en` is low when a request is taken, `resp_valid` rises in the next cycle with `resp_bypass`=1, `resp_pa` equal to the virtual address, no fault, `resp_size`=0 and `resp_pte`=0. No memory access is made.
- R3: The context entry is read from address (`ctx_tbl_ptr` << 4) + 4 × context. Bits [1:0] of every fetched entry give its kind: 0 invalid, 1 table descriptor, 2 page entry, 3 reserved.
- R4: A descriptor's next table base is the descriptor with bits [1:0] cleared, shifted left by 4. The entry address is that base plus 4 × index. The index is VA[31:24] for level 1, VA[23:18] for level 2 and VA[17:12] for level 3. Exactly one read is made per level visited.
- R5: The physical address is the page entry with bits [7:0] cleared, shifted left by 4, plus the offset. The offset is VA[23:0] at level 1 (`resp_size`=2), VA[17:0] at level 2 (`resp_size`=1) and VA[11:0] at level 3 (`resp_size`=0). All addresses are 32 bits wide, and bits above 31 are dropped.
- R6: An invalid entry ends the walk with `resp_fault`=1 and `resp_ftype`=1. A reserved entry, a page entry at the context level, or a descriptor at level 3 ends it with `resp_ftype`=4. `resp_level` gives the stopping level (0 = context, 1 to 3). `resp_pa` and `resp_size` are 0, and `resp_pte` is the offending entry.
- R7: On success, `resp_pte` is the entry with bit 5 (referenced) set, and on writes also bit 6 (modified). The updated entry is written to the address it was read from only if it differs from the entry read. Otherwise no write is made.
- R8: Once `mem_req` is raised, it stays high with `mem_addr`, `mem_we` and `mem_wdata` unchanged until the cycle `mem_ack` is high. Memory latency may be any number of cycles.
- R9: `resp_valid` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mmu_en | input | 1 | Translation enable, sampled when a request is taken |
| ctx_tbl_ptr | input | 28 | Context table base address divided by 16 |
| req_valid | input | 1 | Translation request |
| req_va | input | 32 | Virtual address |
| req_ctx | input | 8 | Context number |
| req_write | input | 1 | 1 for a write access |
| busy | output | 1 | Walk in progress |
| resp_valid | output | 1 | Result pulse |
| resp_bypass | output | 1 | Translation was off; full access |
| resp_fault | output | 1 | Walk ended in a fault |
| resp_ftype | output | 3 | Fault type: 1 invalid, 4 translation error |
| resp_level | output | 2 | Level where the walk stopped |
| resp_pa | output | 32 | Physical address |
| resp_size | output | 2 | Page size: 0 4 KB, 1 256 KB, 2 16 MB |
| resp_pte | output | 32 | Final entry (updated) or faulting entry |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access complete; read data valid |
| mem_rdata | input | 32 | Memory read data |

## Verification
Some properties are checked on every cycle:
- the request/busy relation and the quiet memory port while idle,
- holding of a pending memory request,
- the shape of any write-back word (referenced bit set, page-entry kind),
- the single-cycle result pulse, and bypass results with no memory traffic before them,
- the two legal fault codes with a zero address.

Other behaviour shows up only in the bench's scenarios, which compare results against an independent walk over a table image held in the bench:
- the exact table addresses and index scaling, and the physical address arithmetic for each page size,
- the level a fault is reported at,
- whether a write-back happens at all, seen through the memory's read and write counts and the stored entry.

// File: rtl/mtw_pkg.sv
package mtw_pkg;

  typedef enum logic [1:0] {
    ET_INVALID  = 2'd0,
    ET_TABLE    = 2'd1,
    ET_PAGE     = 2'd2,
    ET_RESERVED = 2'd3
  } ent_type_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FETCH  = 2'd1,
    ST_WRBACK = 2'd2,
    ST_DONE   = 2'd3
  } walk_st_e;

  typedef enum logic [1:0] {
    PG_4K   = 2'd0,
    PG_256K = 2'd1,
    PG_16M  = 2'd2
  } pg_size_e;

  localparam logic [2:0] FT_NONE    = 3'd0;
  localparam logic [2:0] FT_INVALID = 3'd1;
  localparam logic [2:0] FT_TRANS   = 3'd4;

  localparam int REF_BIT = 5;
  localparam int MOD_BIT = 6;

  typedef struct packed {
    logic       descend;
    logic       leaf;
    logic       fault;
    logic [2:0] ftype;
  } ent_verdict_t;

endpackage

// File: rtl/mtw_addr_gen.sv
module mtw_addr_gen #(
  parameter int AW    = 32,
  parameter int CTX_W = 8
) (
  input  logic [AW-5:0]    tbl_ptr,
  input  logic [CTX_W-1:0] ctx,
  input  logic [31:12]     va_idx,
  input  logic [1:0]       nxt_lvl,
  input  logic [AW-7:0]    desc_ptr,
  output logic [AW-1:0]    ctx_addr,
  output logic [AW-1:0]    nxt_addr
);
  localparam int ENT_SH = 2;   // 4 bytes per entry
  localparam int TBL_SH = 4;   // pointer scaling

  logic [AW-1:0] idx_off;
  logic [AW-1:0] nxt_base;

  always_comb begin
    case (nxt_lvl)
      2'd1:    idx_off = AW'({va_idx[31:24], 2'b00});
      2'd2:    idx_off = AW'({va_idx[23:18], 2'b00});
      default: idx_off = AW'({va_idx[17:12], 2'b00});
    endcase
  end

  assign nxt_base = {desc_ptr, 6'b0};
  assign ctx_addr = {tbl_ptr, {TBL_SH{1'b0}}} + (AW'(ctx) << ENT_SH);
  assign nxt_addr = nxt_base + idx_off;

endmodule

// File: rtl/mtw_entry_eval.sv
module mtw_entry_eval
  import mtw_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] entry,
  input  logic [1:0]    lvl,
  input  logic [23:0]   va_off,
  input  logic          wr,
  output ent_verdict_t  verdict,
  output logic [AW-1:0] upd_entry,
  output logic          needs_wb,
  output logic [AW-1:0] pa,
  output pg_size_e      size
);
  localparam logic [1:0] LAST_LVL = 2'd3;

  ent_type_e     etype;
  logic [AW-1:0] frame;
  logic [AW-1:0] offset;

  assign etype = ent_type_e'(entry[1:0]);

  always_comb begin
    verdict = '0;
    case (etype)
      ET_INVALID: begin
        verdict.fault = 1'b1;
        verdict.ftype = FT_INVALID;
      end
      ET_TABLE: begin
        if (lvl == LAST_LVL) begin
          verdict.fault = 1'b1;
          verdict.ftype = FT_TRANS;
        end else begin
          verdict.descend = 1'b1;
        end
      end
      ET_PAGE: begin
        if (lvl == 2'd0) begin
          verdict.fault = 1'b1;
          verdict.ftype = FT_TRANS;
        end else begin
          verdict.leaf = 1'b1;
        end
      end
      default: begin
        verdict.fault = 1'b1;
        verdict.ftype = FT_TRANS;
      end
    endcase
  end

  assign upd_entry = entry | (AW'(1) << REF_BIT) | (AW'(wr) << MOD_BIT);
  assign needs_wb  = verdict.leaf && (upd_entry != entry);

  assign frame = {entry[AW-5:8], 12'b0};

  always_comb begin
    case (lvl)
      2'd1: begin
        offset = AW'(va_off[23:0]);
        size   = PG_16M;
      end
      2'd2: begin
        offset = AW'(va_off[17:0]);
        size   = PG_256K;
      end
      default: begin
        offset = AW'(va_off[11:0]);
        size   = PG_4K;
      end
    endcase
  end

  assign pa = frame + offset;

endmodule

// File: rtl/mmu_table_walker.sv
module mmu_table_walker
  import mtw_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CTX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mmu_en,
  input  logic [AW-5:0]    ctx_tbl_ptr,
  input  logic             req_valid,
  input  logic [AW-1:0]    req_va,
  input  logic [CTX_W-1:0] req_ctx,
  input  logic             req_write,
  output logic             busy,
  output logic             resp_valid,
  output logic             resp_bypass,
  output logic             resp_fault,
  output logic [2:0]       resp_ftype,
  output logic [1:0]       resp_level,
  output logic [AW-1:0]    resp_pa,
  output logic [1:0]       resp_size,
  output logic [AW-1:0]    resp_pte,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [AW-1:0]    mem_wdata,
  input  logic             mem_ack,
  input  logic [AW-1:0]    mem_rdata
);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  // state
  walk_st_e      st_q, st_d;
  logic [1:0]    lvl_q, lvl_d;
  logic [AW-1:0] va_q;
  logic          wr_q;
  logic [AW-1:0] addr_q, addr_d;
  logic [AW-1:0] wdata_q, wdata_d;
  logic          cap_req;

  logic          ld_resp;
  logic          rb_d, rf_d;
  logic [2:0]    rft_d;
  logic [1:0]    rlv_d, rsz_d;
  logic [AW-1:0] rpa_d, rpte_d;
  logic          rb_q, rf_q;
  logic [2:0]    rft_q;
  logic [1:0]    rlv_q, rsz_q;
  logic [AW-1:0] rpa_q, rpte_q;

  // address and entry logic
  logic [AW-1:0] ctx_addr, nxt_addr;
  logic [1:0]    nxt_lvl;
  ent_verdict_t  verdict;
  logic [AW-1:0] upd_entry, leaf_pa;
  logic          needs_wb;
  pg_size_e      leaf_size;

  assign nxt_lvl = 2'(lvl_q + 2'd1);

  mtw_addr_gen #(.AW(AW), .CTX_W(CTX_W)) u_addr (
    .tbl_ptr  (ctx_tbl_ptr),
    .ctx      (req_ctx),
    .va_idx   (va_q[31:12]),
    .nxt_lvl  (nxt_lvl),
    .desc_ptr (mem_rdata[AW-5:2]),
    .ctx_addr (ctx_addr),
    .nxt_addr (nxt_addr)
  );

  mtw_entry_eval #(.AW(AW)) u_eval (
    .entry     (mem_rdata),
    .lvl       (lvl_q),
    .va_off    (va_q[23:0]),
    .wr        (wr_q),
    .verdict   (verdict),
    .upd_entry (upd_entry),
    .needs_wb  (needs_wb),
    .pa        (leaf_pa),
    .size      (leaf_size)
  );

  // next state
  always_comb begin
    st_d    = st_q;
    lvl_d   = lvl_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    cap_req = 1'b0;
    ld_resp = 1'b0;
    rb_d    = 1'b0;
    rf_d    = 1'b0;
    rft_d   = FT_NONE;
    rlv_d   = lvl_q;
    rsz_d   = PG_4K;
    rpa_d   = '0;
    rpte_d  = '0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          cap_req = 1'b1;
          if (!mmu_en) begin
            st_d    = ST_DONE;
            ld_resp = 1'b1;
            rb_d    = 1'b1;
            rlv_d   = 2'd0;
            rpa_d   = req_va;
          end else begin
            st_d   = ST_FETCH;
            lvl_d  = 2'd0;
            addr_d = ctx_addr;
          end
        end
      end
      ST_FETCH: begin
        if (mem_ack) begin
          if (verdict.descend) begin
            lvl_d  = nxt_lvl;
            addr_d = nxt_addr;
          end else if (verdict.leaf) begin
            ld_resp = 1'b1;
            rpa_d   = leaf_pa;
            rsz_d   = leaf_size;
            rpte_d  = upd_entry;
            if (needs_wb) begin
              wdata_d = upd_entry;
              st_d    = ST_WRBACK;
            end else begin
              st_d = ST_DONE;
            end
          end else begin
            ld_resp = 1'b1;
            rf_d    = 1'b1;
            rft_d   = verdict.ftype;
            rpte_d  = mem_rdata;
            st_d    = ST_DONE;
          end
        end
      end
      ST_WRBACK: begin
        if (mem_ack) st_d = ST_DONE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      st_q    <= ST_IDLE;
      lvl_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      st_q    <= st_d;
      lvl_q   <= lvl_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      va_q <= '0;
      wr_q <= 1'b0;
    end else if (cap_req) begin
      va_q <= req_va;
      wr_q <= req_write;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      rb_q   <= 1'b0;
      rf_q   <= 1'b0;
      rft_q  <= FT_NONE;
      rlv_q  <= '0;
      rsz_q  <= '0;
      rpa_q  <= '0;
      rpte_q <= '0;
    end else if (ld_resp) begin
      rb_q   <= rb_d;
      rf_q   <= rf_d;
      rft_q  <= rft_d;
      rlv_q  <= rlv_d;
      rsz_q  <= rsz_d;
      rpa_q  <= rpa_d;
      rpte_q <= rpte_d;
    end
  end

  // outputs
  assign busy        = (st_q != ST_IDLE);
  assign resp_valid  = (st_q == ST_DONE);
  assign resp_bypass = rb_q;
  assign resp_fault  = rf_q;
  assign resp_ftype  = rft_q;
  assign resp_level  = rlv_q;
  assign resp_pa     = rpa_q;
  assign resp_size   = rsz_q;
  assign resp_pte    = rpte_q;
  assign mem_req     = (st_q == ST_FETCH) || (st_q == ST_WRBACK);
  assign mem_we      = (st_q == ST_WRBACK);
  assign mem_addr    = addr_q;
  assign mem_wdata   = wdata_q;

  // checks
  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (req_valid && !busy) |=> busy);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !busy |-> !mem_req);

  // R9
  resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_q)
    resp_valid |=> !resp_valid);

  // R8
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (mem_req && !mem_ack) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R2
  bypass_nomem_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (resp_valid && resp_bypass) |-> (!$past(mem_req) && !resp_fault));

  // R7
  wb_shape_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (mem_req && mem_we) |-> (mem_wdata[REF_BIT] && (mem_wdata[1:0] == 2'd2)));

  // R7
  wb_done_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (mem_req && mem_we && mem_ack) |=> (resp_valid && !resp_fault));

  // R6
  fault_code_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (resp_valid && resp_fault) |->
      (((resp_ftype == FT_INVALID) || (resp_ftype == FT_TRANS)) && (resp_pa == '0)));

endmodule

// File: tb/tb_mmu_table_walker.sv
module tb_mmu_table_walker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mmu_en;
  logic [27:0] ctx_tbl_ptr;
  logic        req_valid;
  logic [31:0] req_va;
  logic [7:0]  req_ctx;
  logic        req_write;
  logic        busy, resp_valid, resp_bypass, resp_fault;
  logic [2:0]  resp_ftype;
  logic [1:0]  resp_level, resp_size;
  logic [31:0] resp_pa, resp_pte;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmu_table_walker dut (
    .clk(clk), .rst_n(rst_n), .mmu_en(mmu_en), .ctx_tbl_ptr(ctx_tbl_ptr),
    .req_valid(req_valid), .req_va(req_va), .req_ctx(req_ctx), .req_write(req_write),
    .busy(busy), .resp_valid(resp_valid), .resp_bypass(resp_bypass),
    .resp_fault(resp_fault), .resp_ftype(resp_ftype), .resp_level(resp_level),
    .resp_pa(resp_pa), .resp_size(resp_size), .resp_pte(resp_pte),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int nchk = 0;
  int nerr = 0;

  task automatic check(string r, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  // memory model
  logic [31:0] mem [logic [31:0]];
  int rd_cnt = 0;
  int wr_cnt = 0;
  int lat = 1;
  int cnt = 0;

  function automatic logic [31:0] rd(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= 32'h0;
      cnt       <= 0;
    end else if (mem_req && !mem_ack) begin
      if (cnt >= lat) begin
        mem_ack <= 1'b1;
        cnt     <= 0;
        if (mem_we) begin
          mem[mem_addr] = mem_wdata;
          wr_cnt++;
        end else begin
          mem_rdata <= rd(mem_addr);
          rd_cnt++;
        end
      end else begin
        cnt <= cnt + 1;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  // expected items
  typedef struct {
    string       tag;
    logic        bypass;
    logic        fault;
    logic [2:0]  ftype;
    logic [1:0]  lvl;
    logic [31:0] pa;
    logic [1:0]  size;
    logic [31:0] pte;
    logic        wb;
    logic [31:0] wb_addr;
    int          nrd;
    int          nwr;
    int          rd0;
    int          wr0;
  } exp_t;

  exp_t sb[$];

  function automatic logic [31:0] idx_of(logic [31:0] va, int l);
    if (l == 1) return {22'b0, va[31:24], 2'b00};
    if (l == 2) return {24'b0, va[23:18], 2'b00};
    return {24'b0, va[17:12], 2'b00};
  endfunction

  function automatic exp_t model(string tag, logic [31:0] va, logic [7:0] ctx,
                                 logic wr, logic en);
    exp_t e;
    logic [31:0] a, ent, npte;
    e.tag = tag; e.bypass = 0; e.fault = 0; e.ftype = 0; e.lvl = 0;
    e.pa = 0; e.size = 0; e.pte = 0; e.wb = 0; e.wb_addr = 0;
    e.nrd = 0; e.nwr = 0; e.rd0 = 0; e.wr0 = 0;
    if (!en) begin
      e.bypass = 1; e.pa = va;
      return e;
    end
    a = {ctx_tbl_ptr, 4'b0} + ({24'b0, ctx} << 2);
    for (int l = 0; l < 4; l++) begin
      ent = rd(a);
      e.nrd++;
      e.lvl = l[1:0];
      case (ent[1:0])
        2'd0: begin e.fault = 1; e.ftype = 3'd1; e.pte = ent; return e; end
        2'd3: begin e.fault = 1; e.ftype = 3'd4; e.pte = ent; return e; end
        2'd1: begin
          if (l == 3) begin e.fault = 1; e.ftype = 3'd4; e.pte = ent; return e; end
          a = ((ent & 32'hFFFF_FFFC) << 4) + idx_of(va, l + 1);
        end
        default: begin
          if (l == 0) begin e.fault = 1; e.ftype = 3'd4; e.pte = ent; return e; end
          npte = ent | 32'h20 | (wr ? 32'h40 : 32'h0);
          e.pte = npte;
          e.wb = (npte != ent);
          e.wb_addr = a;
          e.nwr = e.wb ? 1 : 0;
          if (l == 1) begin e.size = 2; e.pa = ((ent & 32'hFFFF_FF00) << 4) + {8'b0, va[23:0]}; end
          else if (l == 2) begin e.size = 1; e.pa = ((ent & 32'hFFFF_FF00) << 4) + {14'b0, va[17:0]}; end
          else begin e.size = 0; e.pa = ((ent & 32'hFFFF_FF00) << 4) + {20'b0, va[11:0]}; end
          return e;
        end
      endcase
    end
    return e;
  endfunction

  // monitor
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (sb.size() == 0) begin
        check("R9", "unexpected response", 32'h1, 32'h0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, "bypass", {31'b0, resp_bypass}, {31'b0, e.bypass});
        check(e.tag, "fault", {31'b0, resp_fault}, {31'b0, e.fault});
        check(e.tag, "ftype", {29'b0, resp_ftype}, {29'b0, e.ftype});
        check(e.tag, "level", {30'b0, resp_level}, {30'b0, e.lvl});
        check(e.tag, "pa", resp_pa, e.pa);
        check(e.tag, "size", {30'b0, resp_size}, {30'b0, e.size});
        check(e.tag, "pte", resp_pte, e.pte);
        check(e.tag, "reads (R4)", rd_cnt - e.rd0, e.nrd);
        check(e.tag, "writes (R7)", wr_cnt - e.wr0, e.nwr);
        if (e.wb) check(e.tag, "stored entry (R7)", rd(e.wb_addr), e.pte);
      end
    end
  end

  // driver
  task automatic issue(string tag, logic [31:0] va, logic [7:0] ctx, logic wr, logic en);
    exp_t e;
    @(negedge clk);
    while (busy) @(negedge clk);
    e = model(tag, va, ctx, wr, en);
    e.rd0 = rd_cnt;
    e.wr0 = wr_cnt;
    sb.push_back(e);
    req_valid = 1'b1; req_va = va; req_ctx = ctx; req_write = wr; mmu_en = en;
    @(negedge clk);
    req_valid = 1'b0;
    check("R1", "busy after accept", {31'b0, busy}, 32'h1);
    if (!en) check("R2", "bypass result next cycle", {31'b0, resp_valid}, 32'h1);
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL R1 watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_va = '0; req_ctx = '0; req_write = 1'b0;
    mmu_en = 1'b1; ctx_tbl_ptr = 28'h100;
    // context table at 0x1000
    mem[32'h1000] = 32'h0000_0201;  // ctx0 -> L1 at 0x2000
    mem[32'h1004] = 32'h0000_0000;  // ctx1 invalid
    mem[32'h1008] = 32'h0010_0002;  // ctx2 page entry at context level
    // level 1
    mem[32'h2004] = 32'h0000_0301;  // -> L2 at 0x3000
    mem[32'h2008] = 32'h0000_0000;  // invalid
    mem[32'h200C] = 32'h0000_0311;  // -> L2 at 0x3100
    mem[32'h2014] = 32'h0060_0022;  // 16 MB page, referenced already
    mem[32'h2018] = 32'h0000_0003;  // reserved at level 1
    // level 2
    mem[32'h3000] = 32'h0000_0351;  // -> L3 at 0x3500
    mem[32'h3004] = 32'h0000_0341;  // -> L3 at 0x3400
    mem[32'h3008] = 32'h0070_4002;  // 256 KB page
    mem[32'h3100] = 32'h0000_0003;  // reserved
    // level 3
    mem[32'h3414] = 32'h00AB_CD02;  // 4 KB page
    mem[32'h3418] = 32'h0000_0000;  // invalid
    mem[32'h350C] = 32'h0000_0361;  // descriptor at last level
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "busy after reset", {31'b0, busy}, 32'h0);
    check("R9", "resp_valid after reset", {31'b0, resp_valid}, 32'h0);
    check("R1", "mem_req after reset", {31'b0, mem_req}, 32'h0);

    issue("R2", 32'hDEAD_BEEF, 8'd0, 1'b1, 1'b0);
    issue("R5", 32'h0104_5678, 8'd0, 1'b0, 1'b1);   // 4 KB, sets referenced
    issue("R7", 32'h0104_5ABC, 8'd0, 1'b0, 1'b1);   // already referenced: no write
    lat = 3;
    issue("R7", 32'h0104_5000, 8'd0, 1'b1, 1'b1);   // sets modified
    issue("R7", 32'h0104_5FFC, 8'd0, 1'b1, 1'b1);   // nothing changes
    issue("R5", 32'h05AB_CDEF, 8'd0, 1'b0, 1'b1);   // 16 MB read, no write
    lat = 0;
    issue("R5", 32'h05FF_FFFF, 8'd0, 1'b1, 1'b1);   // 16 MB write
    issue("R4", 32'h0108_1234, 8'd0, 1'b1, 1'b1);   // 256 KB, both bits set
    lat = 7;
    issue("R6", 32'h0200_0000, 8'd0, 1'b0, 1'b1);   // invalid at level 1
    issue("R6", 32'h0300_0000, 8'd0, 1'b0, 1'b1);   // reserved at level 2
    issue("R6", 32'h0100_3000, 8'd0, 1'b0, 1'b1);   // descriptor at level 3
    lat = 2;
    issue("R6", 32'h0104_6000, 8'd0, 1'b1, 1'b1);   // invalid at level 3
    issue("R6", 32'h0600_0000, 8'd0, 1'b0, 1'b1);   // reserved at level 1
    issue("R3", 32'h0104_5678, 8'd1, 1'b0, 1'b1);   // context 1 invalid
    issue("R3", 32'h0104_5678, 8'd2, 1'b0, 1'b1);   // page entry at context level
    issue("R2", 32'h0000_0000, 8'd0, 1'b0, 1'b0);
    issue("R8", 32'h0104_5123, 8'd0, 1'b0, 1'b1);   // repeat after latency change
    repeat (3) @(negedge clk);
    check("R9", "pending responses", sb.size(), 32'h0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule